// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block sits on the processor side of a local bus whose sixteen low lines are shared in time between address and data. An internal requester hands it one transfer at a time. The transfer is described by the operation (memory or I/O, read or write, or interrupt acknowledge), the width (byte or word), a 20-bit address, the segment selector in use and, for writes, sixteen bits of data. The sequencer steps the bus through T1, T2, T3, zero or more wait states and T4. In each state it drives the multiplexed lines, the four upper address/status lines, the active-low high-byte enable and the active-low read strobe, and it gives each driver its own output enable so that the pads can be tri-stated.

In T1 the lines carry the address. The byte lanes in use are encoded on the high-byte enable together with address bit 0. From T2 onward the upper lines carry status: the segment selector, a registered copy of the interrupt-enable flag, and a zero. Reads return the value sampled from the bus on the edge that leaves the last T3 or wait state. A `done` pulse marks T4. A hold request is granted only between bus cycles. While hold is granted, every driver is released and `hlda` is raised.

Top module: `mux_bus_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, the block is idle. In that state `done`=0, `hlda`=0, `ad_oe`=0, `rd_n`=1, and `ast_oe`, `bhe_oe` and `rd_oe` are all 1.
- R2: In a cycle where the block is idle (or in T4), `req_valid`=1 and `hold_req`=0, `req_accept` is 1 in that same cycle. The next four cycles are then T1, T2, T3 and T4 when `ready` is high, and `done`=1 only in the T4 cycle.
- R3: In T1 the block drives `ad_out` with address bits 15:0 and `ad_oe`=1. On `ast_out` it drives address bits 19:16 for a memory cycle and 0000 for an I/O cycle (`req_io`=1).
- R4: From T2 through T4, `ast_out` = {0, interrupt-enable status, segment[1:0]}. The segment codes are 00 alternate data, 01 stack, 10 code or none, and 11 data.
- R5: The interrupt-enable status bit, `ast_out[2]`, equals the `ie_flag` value registered at the previous clock edge. It is refreshed every cycle, including in the middle of a bus cycle.
- R6: In T1 of a memory or I/O cycle, `bhe_n` is 0 when the transfer is a word (`req_word`=1) or the address is odd, and 1 otherwise. Read together with address bit 0, the pair gives: 00 whole word, 01 upper byte at an odd address, 10 lower byte at an even address.
- R7: `rd_n` is 0 exactly in T2, T3 and the wait states of a read cycle, and 1 in every other state. Whenever `rd_n` is 0, `ad_oe` is 0.
- R8: `ready` is sampled at the end of T3 and at the end of every wait state. Each low sample adds one wait state, so N low samples delay `done` by N cycles.
- R9: `rdata` holds the value of `ad_in` at the edge that leaves the final T3 or wait state of a read or acknowledge cycle. `done` lasts exactly one cycle.
- R10: In a write cycle, `ad_out` carries the write data with `ad_oe`=1 from T2 through T4, and `ad_oe` is 0 in the cycle after T4.
- R11: In an acknowledge cycle (`req_inta`=1), `ad_oe` is 0 and `rd_n` is 1 in every state. Acknowledge cycles alternate between first and second, starting with first after reset. `bhe_n` is 0 in T1 of the first and 1 in T1 of the second.
- R12: A `hold_req` that is seen while idle or in T4 takes priority over a pending request. From the next cycle, `hlda`=1 and `ad_oe`, `ast_oe`, `bhe_oe` and `rd_oe` are all 0 until `hold_req` drops. `hlda` falls one cycle after the drop. A `hold_req` raised during a bus cycle waits until T4 has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A transfer request is present |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_write | input | 1 | 1 = write, 0 = read |
| req_inta | input | 1 | Interrupt-acknowledge cycle |
| req_word | input | 1 | 1 = word transfer, 0 = byte |
| req_addr | input | 20 | Transfer address |
| req_seg | input | 2 | Segment selector for status |
| req_wdata | input | 16 | Write data |
| ie_flag | input | 1 | Live interrupt-enable flag |
| ready | input | 1 | Slave ready, low inserts wait states |
| hold_req | input | 1 | External request for the bus |
| ad_in | input | 16 | Values on the multiplexed lines |
| req_accept | output | 1 | Request taken this cycle |
| done | output | 1 | One-cycle pulse in T4 |
| rdata | output | 16 | Captured read data |
| ad_out | output | 16 | Drive value for the multiplexed lines |
| ad_oe | output | 1 | Enable for `ad_out` |
| ast_out | output | 4 | Upper address or status lines |
| ast_oe | output | 1 | Enable for `ast_out` |
| bhe_n | output | 1 | High-byte enable, active low |
| bhe_oe | output | 1 | Enable for `bhe_n` |
| rd_n | output | 1 | Read strobe, active low |
| rd_oe | output | 1 | Enable for `rd_n` |
| hlda | output | 1 | Hold acknowledged |

## Verification
The bench moves `ad_in` away from the read value both before and after the capture edge. A sequencer that samples one edge early, or keeps sampling through T4, therefore returns the wrong word. Runs of up to three low `ready` samples catch a design that ignores `ready` in wait states or drops the strobe too soon. Two back-to-back acknowledge cycles expose a missing first/second alternation on `bhe_n`. A hold raised in T2 exposes a design that floats the bus in the middle of a transfer. Changing `ie_flag` in the middle of a cycle catches a status bit that is latched once per cycle rather than refreshed every clock.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    localparam int ADDR_W  = 20;
    localparam int DATA_W  = 16;
    localparam int UPPER_W = ADDR_W - DATA_W;
    localparam int SEG_W   = 2;

    typedef enum logic [2:0] {
        BS_IDLE,
        BS_T1,
        BS_T2,
        BS_T3,
        BS_TW,
        BS_T4,
        BS_HOLD
    } bus_state_e;

    // Segment codes are decoded by the outside world, so the values are fixed.
    typedef enum logic [SEG_W-1:0] {
        SEG_ALT   = 2'b00,
        SEG_STACK = 2'b01,
        SEG_CODE  = 2'b10,
        SEG_DATA  = 2'b11
    } seg_sel_e;

    typedef struct packed {
        logic              io;
        logic              write;
        logic              inta;
        logic              word;
        logic [ADDR_W-1:0] addr;
        seg_sel_e          seg;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    // Upper lane is used for a word, or for any byte at an odd address.
    function automatic logic lane_hi_n(input logic word, input logic a0);
        return !(word || a0);
    endfunction

    function automatic logic [UPPER_W-1:0] status_bits(input logic ie, input seg_sel_e seg);
        return {1'b0, ie, seg};
    endfunction

    function automatic logic in_data_phase(input bus_state_e st);
        return (st == BS_T2) || (st == BS_T3) || (st == BS_TW) || (st == BS_T4);
    endfunction

endpackage

// File: rtl/mbus_ctrl.sv
module mbus_ctrl
    import mbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  bus_req_t   req_in,
    input  logic       ready,
    input  logic       hold_req,
    input  logic       ie_flag,
    output bus_state_e state,
    output bus_req_t   req_q,
    output logic       accept,
    output logic       inta_second,
    output logic       ie_q
);

    bus_state_e state_nx;
    logic       can_start;

    assign can_start = (state == BS_IDLE) || (state == BS_T4);
    assign accept    = can_start && req_valid && !hold_req;

    always_comb begin
        state_nx = state;
        unique case (state)
            BS_IDLE: begin
                if (hold_req)       state_nx = BS_HOLD;
                else if (req_valid) state_nx = BS_T1;
            end
            BS_T1:   state_nx = BS_T2;
            BS_T2:   state_nx = BS_T3;
            BS_T3,
            BS_TW:   state_nx = ready ? BS_T4 : BS_TW;
            BS_T4: begin
                if (hold_req)       state_nx = BS_HOLD;
                else if (req_valid) state_nx = BS_T1;
                else                state_nx = BS_IDLE;
            end
            BS_HOLD: state_nx = hold_req ? BS_HOLD : BS_IDLE;
            default: state_nx = BS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= BS_IDLE;
            req_q       <= '0;
            inta_second <= 1'b0;
            ie_q        <= 1'b0;
        end else begin
            state <= state_nx;
            ie_q  <= ie_flag;
            if (accept)
                req_q <= req_in;
            if (state == BS_T4 && req_q.inta)
                inta_second <= !inta_second;
        end
    end

endmodule

// File: rtl/mbus_pins.sv
module mbus_pins
    import mbus_pkg::*;
(
    input  bus_state_e          state,
    input  bus_req_t            req_q,
    input  logic                inta_second,
    input  logic                ie_q,
    output logic [DATA_W-1:0]   ad_out,
    output logic                ad_oe,
    output logic [UPPER_W-1:0]  ast_out,
    output logic                ast_oe,
    output logic                bhe_n,
    output logic                bhe_oe,
    output logic                rd_n,
    output logic                rd_oe
);

    logic is_read;
    logic is_write;

    assign is_read  = !req_q.write && !req_q.inta;
    assign is_write = req_q.write && !req_q.inta;

    always_comb begin
        ad_out  = '0;
        ad_oe   = 1'b0;
        ast_out = '0;
        ast_oe  = 1'b1;
        bhe_n   = 1'b1;
        bhe_oe  = 1'b1;
        rd_n    = 1'b1;
        rd_oe   = 1'b1;
        if (state == BS_T1) begin
            ad_out  = req_q.addr[DATA_W-1:0];
            ad_oe   = !req_q.inta;
            ast_out = req_q.io ? '0 : req_q.addr[ADDR_W-1:DATA_W];
            bhe_n   = req_q.inta ? inta_second
                                 : lane_hi_n(req_q.word, req_q.addr[0]);
        end else if (in_data_phase(state)) begin
            ast_out = status_bits(ie_q, req_q.seg);
            if (is_write) begin
                ad_out = req_q.wdata;
                ad_oe  = 1'b1;
            end
            rd_n = !(is_read && state != BS_T4);
        end else if (state == BS_HOLD) begin
            ast_oe = 1'b0;
            bhe_oe = 1'b0;
            rd_oe  = 1'b0;
        end
    end

endmodule

// File: rtl/mbus_rcap.sv
module mbus_rcap
    import mbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_state_e        state,
    input  logic              write,
    input  logic              ready,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] rdata
);

    logic last_edge;

    assign last_edge = ((state == BS_T3) || (state == BS_TW)) && ready;

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (last_edge && !write)
            rdata <= ad_in;
    end

endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
    import mbus_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_io,
    input  logic                 req_write,
    input  logic                 req_inta,
    input  logic                 req_word,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [SEG_W-1:0]     req_seg,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic                 ie_flag,
    input  logic                 ready,
    input  logic                 hold_req,
    input  logic [DATA_W-1:0]    ad_in,
    output logic                 req_accept,
    output logic                 done,
    output logic [DATA_W-1:0]    rdata,
    output logic [DATA_W-1:0]    ad_out,
    output logic                 ad_oe,
    output logic [UPPER_W-1:0]   ast_out,
    output logic                 ast_oe,
    output logic                 bhe_n,
    output logic                 bhe_oe,
    output logic                 rd_n,
    output logic                 rd_oe,
    output logic                 hlda
);

    bus_req_t   req_in;
    bus_req_t   req_q;
    bus_state_e state;
    logic       inta_second;
    logic       ie_q;

    always_comb begin
        req_in.io    = req_io;
        req_in.write = req_write;
        req_in.inta  = req_inta;
        req_in.word  = req_word;
        req_in.addr  = req_addr;
        req_in.seg   = seg_sel_e'(req_seg);
        req_in.wdata = req_wdata;
    end

    mbus_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_in      (req_in),
        .ready       (ready),
        .hold_req    (hold_req),
        .ie_flag     (ie_flag),
        .state       (state),
        .req_q       (req_q),
        .accept      (req_accept),
        .inta_second (inta_second),
        .ie_q        (ie_q)
    );

    mbus_pins u_pins (
        .state       (state),
        .req_q       (req_q),
        .inta_second (inta_second),
        .ie_q        (ie_q),
        .ad_out      (ad_out),
        .ad_oe       (ad_oe),
        .ast_out     (ast_out),
        .ast_oe      (ast_oe),
        .bhe_n       (bhe_n),
        .bhe_oe      (bhe_oe),
        .rd_n        (rd_n),
        .rd_oe       (rd_oe)
    );

    mbus_rcap u_rcap (
        .clk   (clk),
        .rst   (rst),
        .state (state),
        .write (req_q.write),
        .ready (ready),
        .ad_in (ad_in),
        .rdata (rdata)
    );

    assign done = (state == BS_T4);
    assign hlda = (state == BS_HOLD);

endmodule

// File: rtl/mbus_chk.sv
module mbus_chk (
    input logic clk,
    input logic rst,
    input logic done,
    input logic rd_n,
    input logic ad_oe,
    input logic ast_oe,
    input logic bhe_oe,
    input logic rd_oe,
    input logic hlda,
    input logic hold_req,
    input logic ready,
    input logic ie_flag,
    input logic ast_s5
);

    assert_strobe_float_R7: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !ad_oe);

    assert_hold_float_R12: assert property (@(posedge clk) disable iff (rst)
        hlda |-> (!ad_oe && !ast_oe && !bhe_oe && !rd_oe));

    assert_hold_kept_R12: assert property (@(posedge clk) disable iff (rst)
        (hlda && hold_req) |=> hlda);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_ready_seen_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(ready));

    assert_ie_refresh_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> (ast_s5 == $past(ie_flag)));

endmodule

bind mux_bus_seq mbus_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .done     (done),
    .rd_n     (rd_n),
    .ad_oe    (ad_oe),
    .ast_oe   (ast_oe),
    .bhe_oe   (bhe_oe),
    .rd_oe    (rd_oe),
    .hlda     (hlda),
    .hold_req (hold_req),
    .ready    (ready),
    .ie_flag  (ie_flag),
    .ast_s5   (ast_out[2])
);

// File: tb/sim_mux_bus_seq.sv
module sim_mux_bus_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 0, req_io = 0, req_write = 0, req_inta = 0, req_word = 0;
    logic [19:0] req_addr = '0;
    logic [1:0]  req_seg = '0;
    logic [15:0] req_wdata = '0;
    logic        ie_flag = 0, ready = 1, hold_req = 0;
    logic [15:0] ad_in = '0;
    logic        req_accept, done, ad_oe, ast_oe, bhe_n, bhe_oe, rd_n, rd_oe, hlda;
    logic [15:0] rdata, ad_out;
    logic [3:0]  ast_out;

    int n_checks = 0;
    int n_fail   = 0;
    logic exp_second = 1'b0;

    always #2.5 clk = ~clk;

    mux_bus_seq u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_io(req_io),
        .req_write(req_write), .req_inta(req_inta), .req_word(req_word),
        .req_addr(req_addr), .req_seg(req_seg), .req_wdata(req_wdata),
        .ie_flag(ie_flag), .ready(ready), .hold_req(hold_req), .ad_in(ad_in),
        .req_accept(req_accept), .done(done), .rdata(rdata), .ad_out(ad_out),
        .ad_oe(ad_oe), .ast_out(ast_out), .ast_oe(ast_oe), .bhe_n(bhe_n),
        .bhe_oe(bhe_oe), .rd_n(rd_n), .rd_oe(rd_oe), .hlda(hlda)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Full bus cycle with nwait low ready samples; checks every state.
    task automatic do_cycle(input logic io, input logic wr, input logic ia, input logic wd,
                            input logic [19:0] addr, input logic [1:0] seg,
                            input logic [15:0] wdat, input int nwait,
                            input logic [15:0] rdv, input string tag);
        logic exp_bhe;
        logic [3:0] st;
        logic is_rd;
        is_rd   = !wr && !ia;
        exp_bhe = ia ? exp_second : !(wd || addr[0]);
        st      = {1'b0, ie_flag, seg};
        req_valid = 1; req_io = io; req_write = wr; req_inta = ia; req_word = wd;
        req_addr = addr; req_seg = seg; req_wdata = wdat; ready = (nwait == 0);
        #0.5;
        check({tag, " R2 accept"}, req_accept, 1);
        step();
        req_valid = 0;
        // T1
        check({tag, " R3 T1 ad_oe"}, ad_oe, !ia);
        if (!ia) check({tag, " R3 T1 addr"}, ad_out, addr[15:0]);
        check({tag, " R3 T1 upper"}, ast_out, io ? 4'h0 : addr[19:16]);
        check({tag, ia ? " R11 T1 bhe_n" : " R6 T1 bhe_n"}, bhe_n, exp_bhe);
        check({tag, " R7 T1 rd_n"}, rd_n, 1);
        check({tag, " R2 T1 done"}, done, 0);
        step();
        // T2
        ad_in = ~rdv;
        check({tag, " R4 T2 status"}, ast_out, st);
        check({tag, " R7 T2 rd_n"}, rd_n, !is_rd);
        check({tag, " R10 T2 ad_oe"}, ad_oe, wr && !ia);
        if (wr) check({tag, " R10 T2 wdata"}, ad_out, wdat);
        step();
        // T3
        ad_in = (nwait == 0) ? rdv : ~rdv;
        check({tag, " R7 T3 rd_n"}, rd_n, !is_rd);
        check({tag, " R2 T3 done"}, done, 0);
        for (int w = 0; w < nwait; w++) begin
            step();
            check({tag, " R8 TW done"}, done, 0);
            check({tag, " R7 TW rd_n"}, rd_n, !is_rd);
            check({tag, " R4 TW status"}, ast_out, st);
            if (w == nwait - 1) begin
                ready = 1;
                ad_in = rdv;
            end
        end
        step();
        // T4
        ad_in = 16'h0F0F ^ rdv;
        check({tag, " R2 T4 done"}, done, 1);
        check({tag, " R7 T4 rd_n"}, rd_n, 1);
        check({tag, " R10 T4 ad_oe"}, ad_oe, wr && !ia);
        check({tag, " R4 T4 status"}, ast_out, st);
        if (!wr) check({tag, " R9 rdata"}, rdata, rdv);
        if (ia) exp_second = !exp_second;
        step();
        check({tag, " R9 done pulse"}, done, 0);
        check({tag, " R10 released"}, ad_oe, 0);
    endtask

    task automatic test_reset();
        rst = 1;
        step(); step();
        check("R1 done", done, 0);
        check("R1 hlda", hlda, 0);
        check("R1 ad_oe", ad_oe, 0);
        check("R1 rd_n", rd_n, 1);
        check("R1 other oe", {ast_oe, bhe_oe, rd_oe}, 3'b111);
        rst = 0;
        step();
        check("R1 idle after", {done, hlda, ad_oe}, 3'b000);
    endtask

    task automatic test_ie_midcycle();
        ie_flag = 0;
        req_valid = 1; req_io = 0; req_write = 0; req_inta = 0; req_word = 1;
        req_addr = 20'h12340; req_seg = 2'b11; ready = 1;
        step();
        req_valid = 0;
        step();                       // T2
        check("R5 T2 ie", ast_out[2], 0);
        ie_flag = 1;
        step();                       // T3
        check("R5 T3 ie refreshed", ast_out[2], 1);
        ie_flag = 0;
        step();                       // T4
        check("R5 T4 ie refreshed", ast_out[2], 0);
        step();
    endtask

    task automatic test_hold_idle();
        hold_req = 1; req_valid = 1; req_addr = 20'h00100; req_write = 0; req_inta = 0;
        #0.5;
        check("R12 hold beats request", req_accept, 0);
        step();
        req_valid = 0;
        check("R12 hlda", hlda, 1);
        check("R12 floated", {ad_oe, ast_oe, bhe_oe, rd_oe}, 4'b0000);
        step();
        check("R12 hlda held", hlda, 1);
        hold_req = 0;
        step();
        check("R12 hlda drop", hlda, 0);
        check("R12 drivers back", {ast_oe, bhe_oe, rd_oe}, 3'b111);
    endtask

    task automatic test_hold_mid();
        req_valid = 1; req_io = 0; req_write = 0; req_inta = 0; req_word = 1;
        req_addr = 20'h2AB00; req_seg = 2'b01; ready = 1; ad_in = 16'h55AA;
        step();
        req_valid = 0;
        step();                       // T2
        hold_req = 1;
        step();                       // T3
        check("R12 no hold in T3", hlda, 0);
        check("R12 read continues", rd_n, 0);
        step();                       // T4
        check("R12 T4 completes", done, 1);
        check("R12 no hold in T4", hlda, 0);
        step();
        check("R12 hold after T4", hlda, 1);
        hold_req = 0;
        step();
        check("R12 release", hlda, 0);
    endtask

    initial begin
        #(5.0 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        test_reset();
        ie_flag = 1;
        do_cycle(0, 0, 0, 1, 20'h5A3C4, 2'b11, 16'h0000, 0, 16'hC3A5, "mem word rd");
        do_cycle(0, 1, 0, 0, 20'hF1235, 2'b01, 16'hBEEF, 0, 16'h0000, "mem byte odd wr");
        ie_flag = 0;
        do_cycle(1, 0, 0, 0, 20'h003A8, 2'b10, 16'h0000, 0, 16'h7E81, "io byte even rd");
        do_cycle(0, 0, 0, 0, 20'h9C001, 2'b00, 16'h0000, 3, 16'h1234, "wait rd");
        do_cycle(0, 1, 0, 1, 20'h40002, 2'b11, 16'hA5F0, 2, 16'h0000, "wait wr");
        do_cycle(0, 0, 1, 0, 20'h00000, 2'b10, 16'h0000, 0, 16'h00FF, "inta first");
        do_cycle(0, 0, 1, 0, 20'h00000, 2'b10, 16'h0000, 1, 16'h0042, "inta second");
        test_ie_midcycle();
        test_hold_idle();
        test_hold_mid();
        finish_up();
    end

endmodule